// File: doc/BRIEF.md
# PRNG Jump-Ahead Sequencer

This block moves the 32-bit state of a small xor/shift/rotate generator a long, fixed distance forward in its sequence. Several consumers can then start from seeds that are far apart and draw numbers that do not overlap for a long time. The distance is set by a 32-bit jump key. Computing that key is left to software.

The block takes a key and a seed when `start_i` is pulsed while it is idle. It then walks the key one bit per cycle, starting at bit 0. On every bit it advances a private copy of the generator by a single step. On each set bit it also XORs the current generator state into an accumulator, which starts at zero. After the last key bit, one commit cycle copies the accumulator to the output register and pulses `done_o`. The output register holds its value until the next commit.

The state is packed as `{hi, lo}`, with two 16-bit halves. One step computes `t = hi ^ lo`, then `lo' = rotl(lo,14) ^ t ^ (t << 2)` and `hi' = rotl(t,7)`, where the shift and rotates are 16-bit operations.

Top module: `prng_jump`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `busy_o` and `done_o` are 0 and `state_o` is 0.
- R2: A `start_i` sampled high while `busy_o` is low raises `busy_o` at the next edge. `busy_o` then stays high for exactly 33 clock cycles.
- R3: `done_o` is high for exactly one cycle. That cycle is the first one in which `busy_o` is low again, and `state_o` carries the new result in that same cycle.
- R4: A key of zero gives a result of zero, whatever the seed.
- R5: Key bit i is the i-th bit scanned, starting from bit 0. A key with only bit i set gives the seed advanced by exactly i single steps.
- R6: For any key, the result is the XOR, over every set key bit i, of the seed advanced by i single steps.
- R7: While `busy_o` is high, `start_i`, `key_i` and `seed_i` have no effect. The result is still that of the key and seed captured at the accepted start, no extra operation follows, and `busy_o` is low in the cycle after `done_o`.
- R8: `state_o` changes only in a cycle in which `done_o` is high.
- R9: One step follows the update rule above, using the amounts 14, 2 and 7 and the layout `{hi, lo}`. A seed of zero always gives a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, accepted only when idle |
| key_i | input | 32 | Jump key, bit 0 scanned first |
| seed_i | input | 32 | Generator state to jump from, `{hi, lo}` |
| busy_o | output | 1 | High while a jump is in progress |
| done_o | output | 1 | One-cycle pulse when the result is committed |
| state_o | output | 32 | Jumped state, held until the next commit |

## Verification
Accepting a start takes one edge, so the bench looks for `busy_o` right after the edge that samples `start_i`. The result and the `done_o` pulse are due 33 edges after that accepting edge: 32 edges for scanning the key and one edge to commit. The bench samples one time unit after each rising edge and counts those edges. A result that comes early or late is reported as a latency failure, separate from a wrong value. The expected value comes from a serial model in the bench that steps the seed once per key bit, and it is compared only in the `done_o` cycle. The cycle after `done_o` is also checked, to confirm that the pulse has ended and that no second operation has started.

// File: rtl/jump_pkg.sv
package jump_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_RUN    = 2'd1,
    PH_COMMIT = 2'd2
  } phase_t;
endpackage

// File: rtl/xoro_step.sv
module xoro_step #(
  parameter int HALF_W = 16,
  parameter int ROT_A  = 14,
  parameter int SHL_B  = 2,
  parameter int ROT_C  = 7
) (
  input  logic [2*HALF_W-1:0] cur_i,
  output logic [2*HALF_W-1:0] nxt_o
);
  logic [HALF_W-1:0] lo, hi, t, lo_n, hi_n;

  always_comb begin
    lo   = cur_i[HALF_W-1:0];
    hi   = cur_i[2*HALF_W-1:HALF_W];
    t    = hi ^ lo;
    lo_n = ((lo << ROT_A) | (lo >> (HALF_W - ROT_A))) ^ t ^ (t << SHL_B);
    hi_n = (t << ROT_C) | (t >> (HALF_W - ROT_C));
    nxt_o = {hi_n, lo_n};
  end
endmodule

// File: rtl/jump_ctrl.sv
module jump_ctrl
  import jump_pkg::*;
#(
  parameter int KEY_W = 32,
  localparam int CNT_W = (KEY_W > 1) ? $clog2(KEY_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             load_o,
  output logic             run_o,
  output logic             commit_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] idx_o
);
  phase_t           phase;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (start_i) phase <= PH_RUN;
        end
        PH_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(KEY_W - 1)) phase <= PH_COMMIT;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign load_o   = (phase == PH_IDLE) && start_i;
  assign run_o    = (phase == PH_RUN);
  assign commit_o = (phase == PH_COMMIT);
  assign busy_o   = (phase != PH_IDLE);
  assign idx_o    = cnt;
endmodule

// File: rtl/jump_datapath.sv
module jump_datapath #(
  parameter int HALF_W = 16,
  parameter int KEY_W  = 32,
  parameter int ROT_A  = 14,
  parameter int SHL_B  = 2,
  parameter int ROT_C  = 7,
  localparam int STATE_W = 2 * HALF_W,
  localparam int CNT_W   = (KEY_W > 1) ? $clog2(KEY_W) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic               run_i,
  input  logic               commit_i,
  input  logic [CNT_W-1:0]   idx_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [STATE_W-1:0] seed_i,
  output logic [STATE_W-1:0] result_o,
  output logic               done_o
);
  logic [STATE_W-1:0] work, acc, work_nxt;
  logic [KEY_W-1:0]   key_q;

  xoro_step #(.HALF_W(HALF_W), .ROT_A(ROT_A), .SHL_B(SHL_B), .ROT_C(ROT_C))
    u_step (.cur_i(work), .nxt_o(work_nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      work     <= '0;
      acc      <= '0;
      key_q    <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= commit_i;
      if (load_i) begin
        work  <= seed_i;
        acc   <= '0;
        key_q <= key_i;
      end else if (run_i) begin
        work <= work_nxt;
        if (key_q[idx_i]) acc <= acc ^ work;
      end
      if (commit_i) result_o <= acc;
    end
  end
endmodule

// File: rtl/prng_jump.sv
module prng_jump #(
  parameter int HALF_W = 16,
  parameter int KEY_W  = 32,
  parameter int ROT_A  = 14,
  parameter int SHL_B  = 2,
  parameter int ROT_C  = 7,
  localparam int STATE_W = 2 * HALF_W,
  localparam int CNT_W   = (KEY_W > 1) ? $clog2(KEY_W) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [STATE_W-1:0] seed_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [STATE_W-1:0] state_o
);
  logic             load, run, commit;
  logic [CNT_W-1:0] idx;

  jump_ctrl #(.KEY_W(KEY_W)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i),
    .load_o(load), .run_o(run), .commit_o(commit),
    .busy_o(busy_o), .idx_o(idx)
  );

  jump_datapath #(
    .HALF_W(HALF_W), .KEY_W(KEY_W),
    .ROT_A(ROT_A), .SHL_B(SHL_B), .ROT_C(ROT_C)
  ) u_dp (
    .clk(clk), .rst(rst), .load_i(load), .run_i(run), .commit_i(commit),
    .idx_i(idx), .key_i(key_i), .seed_i(seed_i),
    .result_o(state_o), .done_o(done_o)
  );
endmodule

// File: rtl/prng_jump_chk.sv
module prng_jump_chk #(
  parameter int KEY_W   = 32,
  parameter int STATE_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [STATE_W-1:0] state_o
);
  logic [15:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst) busy_len <= '0;
    else     busy_len <= busy_o ? busy_len + 1'b1 : '0;
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (busy_len == 16'(KEY_W + 1)));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_at_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(state_o));
endmodule

bind prng_jump prng_jump_chk #(.KEY_W(KEY_W), .STATE_W(STATE_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .state_o(state_o)
);

// File: tb/sim_prng_jump.sv
module sim_prng_jump;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic        start_i = 0;
  logic [31:0] key_i = '0;
  logic [31:0] seed_i = '0;
  logic        busy_o, done_o;
  logic [31:0] state_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  prng_jump u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .key_i(key_i), .seed_i(seed_i),
    .busy_o(busy_o), .done_o(done_o), .state_o(state_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] rl(input logic [15:0] x, input int r);
    return (x << r) | (x >> (16 - r));
  endfunction

  // R9: single step, layout {hi, lo}
  function automatic logic [31:0] ref_step(input logic [31:0] s);
    logic [15:0] lo, hi, t;
    lo = s[15:0];
    hi = s[31:16];
    t  = hi ^ lo;
    return {rl(t, 7), rl(lo, 14) ^ t ^ (t << 2)};
  endfunction

  // R6: XOR of seed stepped i times over every set key bit
  function automatic logic [31:0] ref_jump(input logic [31:0] key, input logic [31:0] seed);
    logic [31:0] a, w;
    a = '0;
    w = seed;
    for (int i = 0; i < 32; i++) begin
      if (key[i]) a ^= w;
      w = ref_step(w);
    end
    return a;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // interfere: drive start with other values mid-operation (R7)
  task automatic run_jump(input logic [31:0] key, input logic [31:0] seed,
                          input string req, input bit interfere);
    logic [31:0] exp;
    int n;
    exp = ref_jump(key, seed);
    @(posedge clk); #1;
    start_i = 1; key_i = key; seed_i = seed;
    @(posedge clk); #1;
    start_i = 0; key_i = ~key; seed_i = seed ^ 32'h5a5a_1234;
    check(busy_o === 1'b1, "R2 busy after start", {31'b0, busy_o}, 32'd1);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      if (interfere && k == 5) start_i = 1;
      if (interfere && k == 9) start_i = 0;
      @(posedge clk); #1;
      n++;
      if (done_o) break;
    end
    start_i = 0;
    check(n == 33 && busy_o === 1'b0, "R2/R3 latency and busy low at done", n, 33);
    check(state_o === exp, req, state_o, exp);
    @(posedge clk); #1;
    check(done_o === 1'b0 && busy_o === 1'b0, "R3/R7 single done pulse, no relaunch",
          {30'b0, busy_o, done_o}, 32'd0);
    check(state_o === exp, "R8 result held", state_o, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    logic [31:0] s;
    repeat (3) @(posedge clk);
    #1;
    check(busy_o === 0 && done_o === 0 && state_o === 0, "R1 during reset",
          state_o, 32'd0);
    rst = 0;
    @(posedge clk); #1;
    check(busy_o === 0 && done_o === 0 && state_o === 0, "R1 after reset",
          state_o, 32'd0);

    run_jump(32'h0, 32'hdead_beef, "R4 zero key", 0);
    run_jump(32'hffff_ffff, 32'h0, "R9 zero seed", 0);

    // R5: one-hot sweep, bit i -> seed stepped i times
    for (int i = 0; i < 32; i++) begin
      s = 32'h0001_0000 ^ (i * 32'h0102_0304);
      if (s == 0) s = 1;
      run_jump(32'h1 << i, s, "R5 one-hot key", 0);
    end

    // R6: mixed keys
    run_jump(32'hffff_ffff, 32'h0000_0001, "R6 all-ones key", 0);
    run_jump(32'h8000_0001, 32'h1234_5678, "R6 end bits", 0);
    lcg = 32'h1357_9bdf;
    for (int i = 0; i < 24; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      s = lcg ^ 32'h9e37_79b9;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      run_jump(lcg, s, "R6 mixed key", 0);
    end

    // R7: start and inputs wiggled while busy
    run_jump(32'h0f0f_a5a5, 32'hcafe_0042, "R7 start ignored while busy", 1);
    run_jump(32'h0000_0100, 32'h0000_8001, "R7 start ignored while busy", 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule